// File: doc/BRIEF.md
# Snooping Cache Line State Controller

This block keeps the coherence state of a small direct-mapped set of cache lines for one processor on a shared broadcast bus. Each line carries a tag and one of three states: invalid, shared or dirty (the only valid copy, locally modified). Processor reads and writes are served locally when the state allows. Otherwise the block asks for the bus with a command, holds the processor stalled until the bus grant arrives, and then updates the line.

The block also watches the transactions that other caches put on the bus. A foreign read that hits a dirty line raises a flush response, so this cache supplies the data, and the line drops to shared. A foreign invalidate or read-exclusive that hits a valid line removes the copy. The data array, the external bus arbiter and memory lie outside the block. Only the grant handshake is seen here.

Address split: the low `INDEX_W` bits select the line and the remaining upper bits form the tag. Command encoding, used on both `bus_cmd` and `snp_cmd`: 2'b00 idle, 2'b01 read, 2'b10 read-exclusive, 2'b11 invalidate.

Top module: `snoop_ctl`

## Requirements
- R1: After reset every line is invalid. A first read to any address raises `bus_req` with command read (01), and a snooped read produces no flush.
- R2: A read whose line is shared or dirty with a matching tag gives `cpu_ready` high in the same cycle, with `bus_req` low.
- R3: A read miss raises `bus_req` with command read (01) and `bus_addr` equal to `cpu_addr`. `cpu_ready` stays low while `bus_gnt` is low and goes high in the cycle `bus_gnt` is high. After that the line is shared.
- R4: A write to a shared line raises `bus_req` with command invalidate (11). On grant the write completes and the line becomes dirty.
- R5: A write miss raises `bus_req` with command read-exclusive (10). On grant the line becomes dirty.
- R6: A write to a dirty line completes in the same cycle, with `cpu_ready` high and `bus_req` low.
- R7: A snooped read that hits a dirty line drives `snp_flush` high in that cycle and leaves the line shared. A snooped read that hits a shared line gives no flush and leaves the line shared.
- R8: A snooped invalidate or read-exclusive that hits a valid line makes it invalid. A snoop whose tag differs from the stored tag has no effect.
- R9: While `snp_valid` is high, `cpu_ready` and `bus_req` stay low.
- R10: An access to a line that holds a different tag is a miss. After the grant, the line takes the new tag and the old one no longer hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until ready |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor address |
| cpu_ready | output | 1 | Access completes this cycle |
| bus_req | output | 1 | Bus transaction request |
| bus_cmd | output | 2 | Bus command (00 when idle) |
| bus_addr | output | ADDR_W | Bus transaction address |
| bus_gnt | input | 1 | Bus granted; transaction takes effect this cycle |
| snp_valid | input | 1 | Foreign bus transaction present |
| snp_cmd | input | 2 | Foreign command |
| snp_addr | input | ADDR_W | Foreign address |
| snp_flush | output | 1 | This cache supplies data for the snooped read |

## Verification
A wrong stored state shows up at the ports on the next access to that line. A line left shared when it should be dirty makes the following write request an invalidate instead of completing at once. A line left valid after a foreign invalidate lets a read hit when it should raise a bus read. A missed dirty state shows up on the next snooped read as an absent flush. Each of these appears in the first cycle of the next access, so the sequences probe each line right after every transition.

// File: rtl/snoop_ctl.sv
module snoop_ctl #(
  parameter int ADDR_W  = 12,
  parameter int INDEX_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_flush
);
  localparam int LINES = 1 << INDEX_W;
  localparam int TAG_W = ADDR_W - INDEX_W;
  localparam logic [1:0] ST_INV = 2'd0, ST_SHD = 2'd1, ST_DRT = 2'd2;
  localparam logic [1:0] CMD_IDLE = 2'd0, CMD_RD = 2'd1, CMD_RDX = 2'd2, CMD_INV = 2'd3;

  logic [1:0]       st [LINES];
  logic [TAG_W-1:0] tg [LINES];

  wire [INDEX_W-1:0] c_idx = cpu_addr[INDEX_W-1:0];
  wire [TAG_W-1:0]   c_tag = cpu_addr[ADDR_W-1:INDEX_W];
  wire [INDEX_W-1:0] s_idx = snp_addr[INDEX_W-1:0];
  wire [TAG_W-1:0]   s_tag = snp_addr[ADDR_W-1:INDEX_W];

  wire c_match  = (st[c_idx] != ST_INV) && (tg[c_idx] == c_tag);
  wire c_dirty  = c_match && (st[c_idx] == ST_DRT);
  wire local_ok = c_match && (!cpu_wr || c_dirty);
  wire s_match  = (st[s_idx] != ST_INV) && (tg[s_idx] == s_tag);
  wire go       = cpu_req && !snp_valid;

  logic [1:0] need_cmd;
  always_comb begin
    if (local_ok)     need_cmd = CMD_IDLE;
    else if (c_match) need_cmd = CMD_INV;
    else if (cpu_wr)  need_cmd = CMD_RDX;
    else              need_cmd = CMD_RD;
  end

  assign bus_req   = go && !local_ok;
  assign bus_cmd   = bus_req ? need_cmd : CMD_IDLE;
  assign bus_addr  = cpu_addr;
  assign cpu_ready = go && (local_ok || bus_gnt);
  assign snp_flush = snp_valid && (snp_cmd == CMD_RD) && s_match && (st[s_idx] == ST_DRT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st[i] <= ST_INV;
    end else if (snp_valid) begin
      if (s_match) begin
        if (snp_cmd == CMD_RD && st[s_idx] == ST_DRT) st[s_idx] <= ST_SHD;
        else if (snp_cmd == CMD_RDX || snp_cmd == CMD_INV) st[s_idx] <= ST_INV;
      end
    end else if (cpu_ready) begin
      if (cpu_wr) st[c_idx] <= ST_DRT;
      else if (bus_req) st[c_idx] <= ST_SHD;
    end
  end

  always_ff @(posedge clk) begin
    if (cpu_ready && bus_req) tg[c_idx] <= c_tag;
  end

  AST_STALL_WITHOUT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |-> !cpu_ready); // R3
  AST_READ_FILL_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && bus_req && !cpu_wr |=> st[$past(c_idx)] == ST_SHD); // R3
  AST_WRITE_OWNS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready && cpu_wr |=> st[$past(c_idx)] == ST_DRT && tg[$past(c_idx)] == $past(c_tag)); // R4
  AST_DIRTY_WRITE_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_wr && c_dirty |-> !bus_req); // R6
  AST_FLUSH_LEAVES_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
    snp_flush |=> st[$past(s_idx)] == ST_SHD); // R7
  AST_SNOOP_KILLS_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && s_match && (snp_cmd == CMD_RDX || snp_cmd == CMD_INV)
    |=> st[$past(s_idx)] == ST_INV); // R8
  AST_SNOOP_BLOCKS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !cpu_ready && !bus_req); // R9
endmodule

// File: tb/snoop_ctl_test.sv
module snoop_ctl_test;
  localparam int AW = 12;
  localparam int NV = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_wr = 0, bus_gnt = 0, snp_valid = 0;
  logic [AW-1:0] cpu_addr = '0, snp_addr = '0;
  logic [1:0] snp_cmd = '0;
  logic cpu_ready, bus_req, snp_flush;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  snoop_ctl #(.ADDR_W(AW), .INDEX_W(3)) uut (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_flush(snp_flush));

  // {req id, op, addr, gnt, exp ready, exp bus_req, exp cmd, exp flush}
  // op: 0 idle, 1 read, 2 write, 3 snoop read, 4 snoop read-exclusive, 5 snoop invalidate
  localparam logic [24:0] VEC [NV] = '{
    {4'd1,  3'd1, 12'h010, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0}, // R1 cold miss
    {4'd3,  3'd1, 12'h010, 1'b1, 1'b1, 1'b1, 2'b01, 1'b0}, // R3 granted fill
    {4'd2,  3'd1, 12'h010, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0}, // R2 shared hit
    {4'd4,  3'd2, 12'h010, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0}, // R4 invalidate request
    {4'd4,  3'd2, 12'h010, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0}, // R4 granted
    {4'd6,  3'd2, 12'h010, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0}, // R6 dirty write local
    {4'd2,  3'd1, 12'h010, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0}, // R2 dirty hit
    {4'd7,  3'd3, 12'h010, 1'b0, 1'b0, 1'b0, 2'b00, 1'b1}, // R7 flush
    {4'd7,  3'd3, 12'h010, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0}, // R7 shared, no flush
    {4'd7,  3'd1, 12'h010, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0}, // R7 still valid
    {4'd7,  3'd2, 12'h010, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0}, // R7 now shared
    {4'd4,  3'd2, 12'h010, 1'b1, 1'b1, 1'b1, 2'b11, 1'b0}, // R4
    {4'd8,  3'd5, 12'h018, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0}, // R8 other tag
    {4'd8,  3'd2, 12'h010, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0}, // R8 untouched
    {4'd8,  3'd4, 12'h010, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0}, // R8 read-exclusive kill
    {4'd8,  3'd1, 12'h010, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0}, // R8 now miss
    {4'd5,  3'd2, 12'h025, 1'b0, 1'b0, 1'b1, 2'b10, 1'b0}, // R5
    {4'd5,  3'd2, 12'h025, 1'b1, 1'b1, 1'b1, 2'b10, 1'b0}, // R5 granted
    {4'd6,  3'd2, 12'h025, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0}, // R6
    {4'd10, 3'd1, 12'h02D, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0}, // R10 conflict miss
    {4'd10, 3'd1, 12'h02D, 1'b1, 1'b1, 1'b1, 2'b01, 1'b0}, // R10 replace
    {4'd10, 3'd3, 12'h025, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0}, // R10 old tag gone
    {4'd10, 3'd1, 12'h02D, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0}, // R10 new tag hits
    {4'd8,  3'd5, 12'h02D, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0}, // R8 invalidate
    {4'd8,  3'd1, 12'h02D, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0}  // R8 miss after kill
  };

  task automatic drive(input logic [2:0] op, input logic [AW-1:0] a, input logic g);
    cpu_req = (op == 3'd1) || (op == 3'd2);
    cpu_wr = (op == 3'd2);
    cpu_addr = a;
    snp_valid = (op >= 3'd3);
    snp_cmd = (op == 3'd3) ? 2'b01 : (op == 3'd4) ? 2'b10 : (op == 3'd5) ? 2'b11 : 2'b00;
    snp_addr = a;
    bus_gnt = g;
  endtask

  task automatic check(input int rid, input logic er, input logic eq, input logic [1:0] ec,
                       input logic ef, input logic [AW-1:0] ea);
    checks++;
    if (cpu_ready !== er || bus_req !== eq || bus_cmd !== ec || snp_flush !== ef ||
        (eq && bus_addr !== ea)) begin
      fails++;
      $display("FAIL R%0d: rdy/req/cmd/flush/addr = %b/%b/%b/%b/%h expected %b/%b/%b/%b/%h",
               rid, cpu_ready, bus_req, bus_cmd, snp_flush, bus_addr, er, eq, ec, ef, ea);
    end
  endtask

  initial begin
    #4000000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i][20:18], VEC[i][17:6], VEC[i][5]);
      #5 check(int'(VEC[i][24:21]), VEC[i][4], VEC[i][3], VEC[i][2:1], VEC[i][0], VEC[i][17:6]);
    end
    // R9: a snoop on the bus holds off the processor
    @(negedge clk);
    drive(3'd1, 12'h02D, 1'b1);
    snp_valid = 1'b1; snp_cmd = 2'b01; snp_addr = 12'h033;
    #5 check(9, 1'b0, 1'b0, 2'b00, 1'b0, 12'h02D);
    @(negedge clk);
    drive(3'd1, 12'h02D, 1'b0);
    #5 check(9, 1'b0, 1'b1, 2'b01, 1'b0, 12'h02D);
    // R1: reset returns a dirty line to invalid
    @(negedge clk);
    drive(3'd2, 12'h025, 1'b1);
    #5 check(5, 1'b1, 1'b1, 2'b10, 1'b0, 12'h025);
    @(negedge clk);
    drive(3'd0, 12'h000, 1'b0);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    drive(3'd3, 12'h025, 1'b0);
    #5 check(1, 1'b0, 1'b0, 2'b00, 1'b0, 12'h025);
    @(negedge clk);
    drive(3'd1, 12'h025, 1'b0);
    #5 check(1, 1'b0, 1'b1, 2'b01, 1'b0, 12'h025);
    @(negedge clk);
    drive(3'd0, 12'h000, 1'b0);
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule